// File: doc/BRIEF.md
# Time-Sliced Shared Memory Hub

This block lets eight processor cores share one memory. A slot counter grants the memory to one core at a time in a fixed rotating order. A slot is not given to another core when its owner has no work, so the delay from a request to its completion depends only on the cycle in which the request was made and never on what the other cores do. In the default mode a slot occurs on every second clock, so each core's turn comes round every 16 clocks. In the fast mode a slot occurs on every clock and each core's turn comes round every 8 clocks.

Each core presents a request of byte, word or long size. The request carries a 32-bit address, write data and byte enables. The hub stores the request until the core's slot arrives. It performs the access in that slot and, on the next clock, pulses a done flag for that core and presents the read data. Only the low 16 address bits are decoded. The lower half of that space is RAM. The upper half is a read-only table whose contents are computed from the address. A remap input turns the upper half into a second writable RAM. Each region holds `DEPTH_LONGS` longs, and an offset larger than that wraps within the region.

Top module: `mem_hub`

## Requirements
- R1: After reset the slot counter is at core 0. In default mode (fast_mode low) a slot occurs in the first cycle after reset and on every second cycle after that, and serves cores 0,1,...,7 in turn, so each core's slot recurs every 16 cycles.
- R2: With fast_mode high from reset, a slot occurs in every cycle. Cycle n after reset belongs to core n mod 8, so each core's slot recurs every 8 cycles.
- R3: A slot is used only by the core that owns it. A slot whose owner has nothing pending passes unused, and at most one core receives done in any cycle.
- R4: A request is captured at the clock edge on which core_req is high and that core has nothing pending. A core_req pulse while the core has a request pending is ignored. The request is served in the core's first slot after the capture edge, and core_done is high for exactly one cycle, the cycle after that slot. core_done is low during reset.
- R5: core_rdata for a core is valid while its core_done is high and keeps that value until the core's next completed read. A write leaves it unchanged.
- R6: Only address bits 15:0 are decoded. Bits 31:16 have no effect on which location is reached.
- R7: Address bit 15 clear selects the RAM region. Bit 15 set selects the table region, whose long at index i reads as {~i8, i8 ^ 8'hA5, i8 + 8'h3C, i8}, where i8 is the low 8 bits of i.
- R8: While rom_remap is low, a write to the table region changes nothing, and the core still receives done.
- R9: While rom_remap is high, the upper region is a writable RAM separate from the lower RAM.
- R10: core_size 0 is byte, 1 is word, and 2 or 3 is long. Word accesses ignore address bit 0 and long accesses ignore bits 1:0. Write data and read data are right-justified: the low byte of the data goes to the byte at the aligned address, and read data is zero-extended.
- R11: Byte enable bit j writes data byte j of the right-justified value. Only the enable bits within the access size take part.
- R12: Within a region, the long index is the address bits above bit 1 taken modulo DEPTH_LONGS, so addresses that differ by a multiple of 4*DEPTH_LONGS reach the same long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | High: a slot on every clock; low: a slot on every second clock |
| rom_remap | input | 1 | High: the upper region becomes RAM |
| core_req | input | NCORES | Request strobe per core |
| core_we | input | NCORES | Write (1) or read (0) per core |
| core_size | input | 2*NCORES | Access size per core (0 byte, 1 word, 2/3 long) |
| core_addr | input | 32*NCORES | Byte address per core |
| core_wdata | input | 32*NCORES | Right-justified write data per core |
| core_be | input | 4*NCORES | Byte enables per core |
| core_rdata | output | 32*NCORES | Right-justified read data per core |
| core_done | output | NCORES | One-cycle completion pulse per core |

## Verification
The bench builds the hub with eight cores and DEPTH_LONGS set to 16, so each region is only 64 bytes. At that size every byte offset of the lower RAM can be read at all three sizes, every long of the table can be compared with its formula, and wrap-around within a region is reached by addresses just above 64. Completion cycles are predicted from the count of cycles since reset, in both slot modes, for single requests and for a burst from all eight cores at once.

// File: rtl/hub_pkg.sv
package hub_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONG_ALT = 2'd3
    } hub_size_e;

    typedef struct packed {
        logic        we;
        hub_size_e   size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
    } hub_req_t;

    // Clear the low address bits that the access size does not use.
    function automatic logic [15:0] align16(input logic [15:0] a, input hub_size_e s);
        case (s)
            SZ_BYTE: return a;
            SZ_WORD: return {a[15:1], 1'b0};
            default: return {a[15:2], 2'b00};
        endcase
    endfunction

    // Byte enables that take part for a given access size.
    function automatic logic [3:0] size_mask(input hub_size_e s, input logic [3:0] be);
        case (s)
            SZ_BYTE: return {3'b000, be[0]};
            SZ_WORD: return {2'b00, be[1:0]};
            default: return be;
        endcase
    endfunction

    // Contents of the read-only table, computed from the long index.
    function automatic logic [31:0] table_long(input logic [7:0] i);
        return {~i, i ^ 8'hA5, i + 8'h3C, i};
    endfunction

    // Right-justify and zero-extend a read value.
    function automatic logic [31:0] extract(input logic [31:0] l, input logic [1:0] lane,
                                            input hub_size_e s);
        logic [31:0] sh;
        sh = l >> {lane, 3'b000};
        case (s)
            SZ_BYTE: return {24'h0, sh[7:0]};
            SZ_WORD: return {16'h0, sh[15:0]};
            default: return sh;
        endcase
    endfunction

endpackage

// File: rtl/hub_slot_timer.sv
module hub_slot_timer #(
    parameter int NCORES = 8,
    localparam int SLOT_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_mode,
    output logic [SLOT_W-1:0] slot_core,
    output logic              slot_valid
);

    logic phase_q;

    assign slot_valid = fast_mode | phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= 1'b1;
            slot_core <= '0;
        end else begin
            phase_q <= fast_mode ? 1'b1 : ~phase_q;
            if (slot_valid) begin
                if (slot_core == SLOT_W'(NCORES - 1))
                    slot_core <= '0;
                else
                    slot_core <= slot_core + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hub_req_slot.sv
module hub_req_slot
    import hub_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  hub_req_t    req_d,
    input  logic        serve_i,
    input  logic        rd_load_i,
    input  logic [31:0] rd_value_i,
    output logic        pending_o,
    output hub_req_t    held_o,
    output logic [31:0] rdata_o
);

    logic [31:0] rd_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_o <= 1'b0;
            held_o    <= '0;
        end else if (serve_i) begin
            pending_o <= 1'b0;
        end else if (req_i && !pending_o) begin
            pending_o <= 1'b1;
            held_o    <= req_d;
        end
    end

    assign rdata_o = rd_load_i ? rd_value_i : rd_hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            rd_hold_q <= '0;
        else
            rd_hold_q <= rdata_o;
    end

endmodule

// File: rtl/hub_mem_bank.sv
module hub_mem_bank
    import hub_pkg::*;
#(
    parameter int DEPTH_LONGS = 256,
    localparam int IDX_W = $clog2(DEPTH_LONGS)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic             upper,
    input  logic             remap,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       bmask,
    input  logic [31:0]      wlong,
    output logic [31:0]      rd_long
);

    logic [31:0] ram_lo [DEPTH_LONGS];
    logic [31:0] ram_hi [DEPTH_LONGS];

    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int b = 0; b < 4; b++) begin
                if (bmask[b]) begin
                    if (!upper)
                        ram_lo[idx][8*b +: 8] <= wlong[8*b +: 8];
                    else if (remap)
                        ram_hi[idx][8*b +: 8] <= wlong[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (en && !we) begin
            if (!upper)
                rd_long <= ram_lo[idx];
            else if (remap)
                rd_long <= ram_hi[idx];
            else
                rd_long <= table_long(8'(idx));
        end
    end

endmodule

// File: rtl/mem_hub.sv
module mem_hub
    import hub_pkg::*;
#(
    parameter int NCORES = 8,
    parameter int DEPTH_LONGS = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fast_mode,
    input  logic                 rom_remap,
    input  logic [NCORES-1:0]    core_req,
    input  logic [NCORES-1:0]    core_we,
    input  logic [2*NCORES-1:0]  core_size,
    input  logic [32*NCORES-1:0] core_addr,
    input  logic [32*NCORES-1:0] core_wdata,
    input  logic [4*NCORES-1:0]  core_be,
    output logic [32*NCORES-1:0] core_rdata,
    output logic [NCORES-1:0]    core_done
);

    localparam int SLOT_W = (NCORES > 1) ? $clog2(NCORES) : 1;
    localparam int IDX_W  = $clog2(DEPTH_LONGS);

    logic [SLOT_W-1:0] slot_core;
    logic              slot_valid;
    logic [NCORES-1:0] pending;
    logic [NCORES-1:0] serve_vec;
    hub_req_t          req_in [NCORES];
    hub_req_t          held   [NCORES];

    hub_req_t          cur;
    logic              serve;
    logic [15:0]       a16;
    logic [3:0]        bmask;
    logic [31:0]       wlong;
    logic [31:0]       rd_long;
    logic [31:0]       rd_value;
    logic              unused_addr_hi;

    logic              stg_valid;
    logic [SLOT_W-1:0] stg_core;
    logic              stg_we;
    logic [1:0]        stg_lane;
    hub_size_e         stg_size;

    hub_slot_timer #(.NCORES(NCORES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .fast_mode  (fast_mode),
        .slot_core  (slot_core),
        .slot_valid (slot_valid)
    );

    // Request of the core that owns the current slot.
    assign cur   = held[slot_core];
    assign serve = slot_valid & pending[slot_core];

    // Address decode: only the low half-word of the address is used.
    assign a16            = align16(cur.addr[15:0], cur.size);
    assign unused_addr_hi = ^cur.addr[31:16];
    assign bmask          = size_mask(cur.size, cur.be) << a16[1:0];
    assign wlong          = cur.wdata << {a16[1:0], 3'b000};

    hub_mem_bank #(.DEPTH_LONGS(DEPTH_LONGS)) u_bank (
        .clk     (clk),
        .en      (serve),
        .we      (cur.we),
        .upper   (a16[15]),
        .remap   (rom_remap),
        .idx     (a16[2 +: IDX_W]),
        .bmask   (bmask),
        .wlong   (wlong),
        .rd_long (rd_long)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_valid <= 1'b0;
            stg_core  <= '0;
            stg_we    <= 1'b0;
            stg_lane  <= '0;
            stg_size  <= SZ_BYTE;
        end else begin
            stg_valid <= serve;
            stg_core  <= slot_core;
            stg_we    <= cur.we;
            stg_lane  <= a16[1:0];
            stg_size  <= cur.size;
        end
    end

    assign rd_value = extract(rd_long, stg_lane, stg_size);

    for (genvar k = 0; k < NCORES; k++) begin : g_core
        always_comb begin
            req_in[k].we    = core_we[k];
            req_in[k].size  = hub_size_e'(core_size[2*k +: 2]);
            req_in[k].addr  = core_addr[32*k +: 32];
            req_in[k].wdata = core_wdata[32*k +: 32];
            req_in[k].be    = core_be[4*k +: 4];
        end

        assign serve_vec[k] = serve && (slot_core == SLOT_W'(k));
        assign core_done[k] = stg_valid && (stg_core == SLOT_W'(k));

        hub_req_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .req_i      (core_req[k]),
            .req_d      (req_in[k]),
            .serve_i    (serve_vec[k]),
            .rd_load_i  (core_done[k] && !stg_we),
            .rd_value_i (rd_value),
            .pending_o  (pending[k]),
            .held_o     (held[k]),
            .rdata_o    (core_rdata[32*k +: 32])
        );
    end

endmodule

// File: rtl/hub_checker.sv
module hub_checker #(
    parameter int NCORES = 8,
    localparam int SLOT_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              fast_mode,
    input logic [SLOT_W-1:0] slot_core,
    input logic              slot_valid,
    input logic [NCORES-1:0] pending,
    input logic [NCORES-1:0] core_done
);

    // R1
    slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!fast_mode && slot_valid) |=> (fast_mode || !slot_valid));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_valid |=> $stable(slot_core));

    // R2
    fast_every_chk: assert property (@(posedge clk) disable iff (rst)
        fast_mode |-> slot_valid);

    // R3
    one_done_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_done));

    for (genvar k = 0; k < NCORES; k++) begin : g_chk
        // R3
        done_owner_chk: assert property (@(posedge clk) disable iff (rst)
            core_done[k] |-> ($past(slot_valid) && $past(slot_core) == SLOT_W'(k)));

        // R4
        done_pending_chk: assert property (@(posedge clk) disable iff (rst)
            core_done[k] |-> ($past(pending[k]) && !pending[k]));

        // R4
        done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            core_done[k] |=> !core_done[k]);
    end

endmodule

bind mem_hub hub_checker #(.NCORES(NCORES)) u_hub_checker (
    .clk        (clk),
    .rst        (rst),
    .fast_mode  (fast_mode),
    .slot_core  (slot_core),
    .slot_valid (slot_valid),
    .pending    (pending),
    .core_done  (core_done)
);

// File: tb/test_mem_hub.sv
module test_mem_hub;

    localparam int NC = 8;
    localparam int DEPTH = 16;
    localparam int RBYTES = 4 * DEPTH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fast = 1'b0;
    logic remap = 1'b0;

    logic [NC-1:0]    core_req;
    logic [NC-1:0]    core_we;
    logic [2*NC-1:0]  core_size;
    logic [32*NC-1:0] core_addr;
    logic [32*NC-1:0] core_wdata;
    logic [4*NC-1:0]  core_be;
    logic [32*NC-1:0] core_rdata;
    logic [NC-1:0]    core_done;

    logic        b_req   [NC];
    logic        b_we    [NC];
    logic [1:0]  b_size  [NC];
    logic [31:0] b_addr  [NC];
    logic [31:0] b_wdata [NC];
    logic [3:0]  b_be    [NC];

    for (genvar k = 0; k < NC; k++) begin : g_drv
        assign core_req[k]             = b_req[k];
        assign core_we[k]              = b_we[k];
        assign core_size[2*k +: 2]     = b_size[k];
        assign core_addr[32*k +: 32]   = b_addr[k];
        assign core_wdata[32*k +: 32]  = b_wdata[k];
        assign core_be[4*k +: 4]       = b_be[k];
    end

    mem_hub #(.NCORES(NC), .DEPTH_LONGS(DEPTH)) i_mem_hub (
        .clk        (clk),
        .rst        (rst),
        .fast_mode  (fast),
        .rom_remap  (remap),
        .core_req   (core_req),
        .core_we    (core_we),
        .core_size  (core_size),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .core_be    (core_be),
        .core_rdata (core_rdata),
        .core_done  (core_done)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always_ff @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    int checks = 0;
    int fails = 0;
    logic [7:0] m_lo [RBYTES];
    logic [7:0] m_hi [RBYTES];

    int bd [NC];
    int bi [NC];
    logic [31:0] br [NC];
    bit bs [NC];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] al(input logic [15:0] a, input int sz);
        if (sz == 0) return a;
        if (sz == 1) return {a[15:1], 1'b0};
        return {a[15:2], 2'b00};
    endfunction

    function automatic logic [7:0] get_byte(input bit up, input int off);
        logic [7:0] i;
        if (!up) return m_lo[off];
        if (remap) return m_hi[off];
        i = 8'(off / 4);
        case (off % 4)
            0: return i;
            1: return i + 8'h3C;
            2: return i ^ 8'hA5;
            default: return ~i;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] addr, input int sz);
        logic [15:0] a;
        logic [31:0] v;
        int n;
        a = al(addr[15:0], sz);
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        v = '0;
        for (int j = 0; j < n; j++)
            v[8*j +: 8] = get_byte(a[15], (int'(a) + j) % RBYTES);
        return v;
    endfunction

    function automatic void model_write(input logic [31:0] addr, input int sz,
                                        input logic [31:0] wd, input logic [3:0] be);
        logic [15:0] a;
        int n;
        a = al(addr[15:0], sz);
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int j = 0; j < n; j++) begin
            if (be[j]) begin
                if (!a[15]) m_lo[(int'(a) + j) % RBYTES] = wd[8*j +: 8];
                else if (remap) m_hi[(int'(a) + j) % RBYTES] = wd[8*j +: 8];
            end
        end
    endfunction

    function automatic int exp_done(input int k, input int t);
        for (int s = t + 1; s < t + 64; s++) begin
            if (fast) begin
                if (s % NC == k) return s + 1;
            end else if ((s % 2 == 0) && ((s / 2) % NC == k)) begin
                return s + 1;
            end
        end
        return -2;
    endfunction

    task automatic access(input int k, input bit we, input int sz, input logic [31:0] addr,
                          input logic [31:0] wd, input logic [3:0] be,
                          output logic [31:0] rd, output int icyc, output int dcyc,
                          output bit stray);
        @(negedge clk);
        b_we[k] = we; b_size[k] = 2'(sz); b_addr[k] = addr;
        b_wdata[k] = wd; b_be[k] = be; b_req[k] = 1'b1;
        icyc = cyc; dcyc = -1; rd = '0; stray = 1'b0;
        @(negedge clk);
        b_req[k] = 1'b0;
        for (int n = 0; n < 64; n++) begin
            if (core_done[k]) begin
                dcyc = cyc;
                rd = core_rdata[32*k +: 32];
                break;
            end
            if ((core_done & ~(NC'(1) << k)) != '0) stray = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic rd_chk(input int k, input int sz, input logic [31:0] addr, input string tag);
        logic [31:0] rd;
        int ic, dc;
        bit st;
        access(k, 1'b0, sz, addr, '0, 4'h0, rd, ic, dc, st);
        chk(rd == exp_read(addr, sz), tag, rd, exp_read(addr, sz));
    endtask

    task automatic wr(input int k, input int sz, input logic [31:0] addr,
                      input logic [31:0] wd, input logic [3:0] be, input string tag);
        logic [31:0] rd;
        int ic, dc;
        bit st;
        access(k, 1'b1, sz, addr, wd, be, rd, ic, dc, st);
        model_write(addr, sz, wd, be);
        chk(dc == exp_done(k, ic), tag, 32'(dc), 32'(exp_done(k, ic)));
    endtask

    task automatic lat_chk(input int k, input string tag);
        logic [31:0] rd;
        int ic, dc;
        bit st;
        access(k, 1'b0, 2, 32'h0000_8000 + 32'(4 * k), '0, 4'h0, rd, ic, dc, st);
        chk(dc == exp_done(k, ic), tag, 32'(dc), 32'(exp_done(k, ic)));
        chk(!st, "R3 no done for other cores", 32'(st), 32'd0);
        @(negedge clk);
        chk(core_done[k] == 1'b0, "R4 done lasts one cycle", 32'(core_done[k]), 32'd0);
    endtask

    task automatic do_reset(input bit f, input bit rm);
        @(negedge clk);
        rst = 1'b1; fast = f; remap = rm;
        repeat (3) @(negedge clk);
        chk(core_done == '0, "R4 done low in reset", 32'(core_done), 32'd0);
        rst = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < NC; k++) begin
            b_req[k] = 1'b0; b_we[k] = 1'b0; b_size[k] = 2'd0;
            b_addr[k] = '0; b_wdata[k] = '0; b_be[k] = 4'h0;
        end
        for (int i = 0; i < RBYTES; i++) begin
            m_lo[i] = 8'h00; m_hi[i] = 8'h00;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] rd, prev;
        int ic, dc;
        bit st;

        // Default mode, upper region read-only.
        do_reset(1'b0, 1'b0);

        // R4: second request while pending is ignored; core 2 slot is cycle 4.
        b_we[2] = 1'b0; b_size[2] = 2'd2; b_addr[2] = 32'h0000_800C; b_req[2] = 1'b1;
        @(negedge clk); b_req[2] = 1'b0;
        @(negedge clk); b_addr[2] = 32'h0000_8024; b_req[2] = 1'b1;
        @(negedge clk); b_req[2] = 1'b0;
        dc = -1; rd = '0;
        for (int n = 0; n < 30; n++) begin
            if (core_done[2]) begin
                if (dc < 0) begin dc = cyc; rd = core_rdata[95:64]; end
                else dc = 999;
            end
            @(negedge clk);
        end
        chk(dc == 5, "R4 capture then serve in slot", 32'(dc), 32'd5);
        chk(rd == exp_read(32'h0000_800C, 2), "R4 pending request ignores new pulse",
            rd, exp_read(32'h0000_800C, 2));

        // R1: slot order and latency in default mode.
        for (int k = 0; k < NC; k++) lat_chk(k, "R1 default-mode done cycle");
        lat_chk(5, "R1 default-mode repeat");

        // R7: every long of the table region.
        for (int i = 0; i < DEPTH; i++)
            rd_chk(i % NC, 2, 32'h0000_8000 + 32'(4 * i), "R7 table contents");

        // R8: write to table region discarded, done still given.
        wr(4, 2, 32'h0000_8010, 32'hDEAD_BEEF, 4'hF, "R8 done for table write");
        rd_chk(4, 2, 32'h0000_8010, "R8 table unchanged");
        wr(6, 0, 32'h0000_8005, 32'h0000_0077, 4'h1, "R8 done for table byte write");
        rd_chk(6, 0, 32'h0000_8005, "R8 table byte unchanged");

        // Fill lower RAM with longs, high address bits set (R6).
        for (int i = 0; i < DEPTH; i++)
            wr(i % NC, 2, {16'(i * 16'h1111 + 16'h0A0B), 16'(4 * i)},
               32'(i) * 32'h0103_0507 ^ 32'hA5C3_0F96, 4'hF, "R6 long write done");

        // R10/R6: every byte offset at every size.
        for (int off = 0; off < RBYTES; off++)
            for (int sz = 0; sz < 3; sz++)
                rd_chk((off + sz) % NC, sz, {16'(off * 1237 + 7), 16'(off)}, "R10 sized read");

        // R10: alignment of word and long writes.
        wr(1, 1, 32'h0000_001B, 32'h0000_C0DE, 4'h3, "R10 word write done");
        rd_chk(1, 2, 32'h0000_0018, "R10 word ignores bit 0");
        wr(3, 2, 32'h0000_0027, 32'h1234_5678, 4'hF, "R10 long write done");
        rd_chk(3, 2, 32'h0000_0024, "R10 long ignores bits 1:0");
        wr(5, 0, 32'h0000_0031, 32'hFFFF_FF5A, 4'hF, "R10 byte write done");
        rd_chk(5, 2, 32'h0000_0030, "R10 byte lane");

        // R11: every byte-enable pattern.
        for (int be = 0; be < 16; be++) begin
            wr(be % NC, 2, 32'h0000_000C, 32'h1111_1111 * 32'(be + 1), 4'(be), "R11 write done");
            rd_chk(be % NC, 2, 32'h0000_000C, "R11 byte enables");
        end
        wr(2, 1, 32'h0000_0012, 32'hFFFF_ABCD, 4'hE, "R11 word enables done");
        rd_chk(2, 2, 32'h0000_0010, "R11 word with upper enables only");

        // R12: wrap within a region.
        wr(7, 2, 32'h0000_0048, 32'hCAFE_F00D, 4'hF, "R12 alias write done");
        rd_chk(7, 2, 32'h0000_0008, "R12 alias reaches low long");
        rd_chk(0, 2, 32'h0000_7FC8, "R12 top of region aliases");

        // R6: high address bits only.
        rd_chk(1, 2, 32'hFFFF_0008, "R6 high bits ignored");
        rd_chk(2, 2, 32'hFFFF_E000, "R6 high bits table");

        // R5: rdata held across a write.
        access(1, 1'b0, 2, 32'h0000_0000, '0, 4'h0, prev, ic, dc, st);
        access(1, 1'b1, 2, 32'h0000_0004, 32'h0BAD_0BAD, 4'hF, rd, ic, dc, st);
        model_write(32'h0000_0004, 2, 32'h0BAD_0BAD, 4'hF);
        chk(rd == prev, "R5 rdata held over write", rd, prev);
        repeat (5) @(negedge clk);
        chk(core_rdata[63:32] == prev, "R5 rdata held idle", core_rdata[63:32], prev);

        // Fast mode.
        do_reset(1'b1, 1'b0);
        for (int k = NC - 1; k >= 0; k--) lat_chk(k, "R2 fast-mode done cycle");
        lat_chk(0, "R2 fast-mode repeat");

        // R3/R2: all cores at once.
        for (int k = 0; k < NC; k++) begin
            automatic int kk = k;
            fork
                access(kk, 1'b0, 2, 32'(4 * kk), '0, 4'h0, br[kk], bi[kk], bd[kk], bs[kk]);
            join_none
        end
        wait fork;
        for (int k = 0; k < NC; k++) begin
            chk(bd[k] == exp_done(k, bi[k]), "R3 burst done cycle", 32'(bd[k]),
                32'(exp_done(k, bi[k])));
            chk(br[k] == exp_read(32'(4 * k), 2), "R3 burst data", br[k], exp_read(32'(4 * k), 2));
        end

        // R9: upper region as RAM.
        do_reset(1'b1, 1'b1);
        for (int i = 0; i < DEPTH; i++)
            wr(i % NC, 2, 32'h0000_8000 + 32'(4 * i), 32'h5A00_0000 | 32'(i * 7), 4'hF,
               "R9 upper write done");
        for (int i = 0; i < DEPTH; i++) begin
            rd_chk((i + 3) % NC, 2, 32'h0000_8000 + 32'(4 * i), "R9 upper RAM readback");
            rd_chk((i + 5) % NC, 2, 32'(4 * i), "R9 lower RAM separate");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule